// File: doc/BRIEF.md
# Serial EEPROM Boot Reader

This block is a two-wire bus master that fetches boot data from a serial EEPROM. A request carries a byte count. The block then runs a fixed transaction on the bus:

1. A START condition.
2. The device byte with the write direction.
3. A two-byte internal start address.
4. A repeated START.
5. The device byte with the read direction.
6. Sequential reads of the requested number of bytes.

It never re-addresses the memory. Instead it relies on the EEPROM advancing its own address pointer after every byte. Each received byte appears on a byte-stream output with a one-cycle valid strobe.

Both bus lines are open-drain. The block only ever pulls a line low or releases it, and it reads the resolved level back on separate inputs. Bus timing comes from two parameters:

- A prescaler turns the system clock into ticks.
- A 16-bit divider word sets the SCL low time (low byte) and the SCL high time (high byte), both counted in ticks.

The high-time count holds while a slave keeps SCL low. If the slave does not acknowledge any byte the block writes, the block ends the transfer with a STOP and raises an error flag.

Top module: `i2c_boot_reader`

## Requirements
- R1: After reset both bus lines are released (`scl_oe`=0, `sda_oe`=0) and `busy`, `done`, `err` and `rd_valid` are 0.
- R2: A request runs START, byte 0xA0 (7-bit device address 0x50 in bits 7:1, bit 0 = 0 for write), address byte 0x00, address byte 0x00, repeated START, byte 0xA1 (bit 0 = 1 for read). Every byte goes out MSB first, and the ninth clock of each byte is the acknowledge slot.
- R3: Exactly `len` bytes are delivered on `rd_data`, each with a one-cycle `rd_valid` pulse, in memory order starting at internal address 0.
- R4: In the acknowledge slot the master pulls SDA low after every received byte except the last. After the last byte it leaves SDA high (NACK) and then issues a STOP.
- R5: If SDA is high in the acknowledge slot of any of the four written bytes, the block issues a STOP, sets `err`, and delivers no data.
- R6: With no clock stretching, every SCL low period lasts `CLKDIV[7:0]*PRESCALE` clocks and every bit-slot SCL high period lasts `CLKDIV[15:8]*PRESCALE` clocks. With the defaults (prescale 0xA, divider 0x0811) this gives 170 and 80 clocks.
- R7: SDA changes only while SCL is low, except for START, repeated START and STOP. A read of n bytes therefore shows two START edges and one STOP edge.
- R8: While the master has released SCL but the line stays low, the high-time count holds. The high period therefore starts only once SCL is actually high, and the data still arrives intact.
- R9: A request with `len`=0 is ignored, and a request made while `busy` is 1 is ignored.
- R10: `done` pulses for one cycle when the STOP completes. `err` stays set until the next accepted request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a boot read (accepted when idle and len is non-zero) |
| len | input | LEN_W | Number of bytes to read |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| err | output | 1 | Slave did not acknowledge a written byte |

## Verification
Each received byte reaches `rd_valid` one clock after the end of the SCL high phase of its eighth bit. `done` rises one clock after the final STOP phase ends, and at that same edge `busy` falls. The bench samples all outputs on the falling clock edge, so these registered results are captured after they settle. It checks totals only after `done` has been observed.

Bus timing is measured in the bench as the elapsed time between SCL edges divided by the 8 ns clock period. The bench counts START and STOP edges from the resolved lines. These measurements are compared with the products of the prescaler and divider values, independently of when the block's registers change.

// File: rtl/i2c_boot_reader.sv
module i2c_boot_reader #(
  parameter int          PRESCALE   = 10,
  parameter logic [15:0] CLKDIV     = 16'h0811,
  parameter int          LEN_W      = 16,
  parameter logic [6:0]  DEV_ADDR   = 7'h50,
  parameter logic [15:0] START_ADDR = 16'h0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [LEN_W-1:0] len,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam logic [7:0] LO_T = CLKDIV[7:0];
  localparam logic [7:0] HI_T = CLKDIV[15:8];
  localparam int         PW   = $clog2(PRESCALE + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_RSTART, S_STOP} st_t;

  st_t             st;
  logic [1:0]      ph;
  logic [PW-1:0]   pcnt;
  logic [7:0]      tcnt;
  logic [3:0]      bitn;
  logic [2:0]      stage;
  logic [7:0]      shreg;
  logic [LEN_W-1:0] left;
  logic            sda_q, want;

  wire       reading = (stage == 3'd4);
  assign     scl_oe  = (st == S_BIT || st == S_RSTART || st == S_STOP) && ph == 2'd0;
  wire [7:0] dur     = scl_oe ? LO_T : HI_T;
  wire       run     = scl_oe | scl_i;
  wire       step    = run && pcnt == PW'(PRESCALE - 1);
  wire       end_ph  = step && tcnt == dur - 8'd1;
  assign     sda_oe  = sda_q;
  assign     busy    = (st != S_IDLE);

  always_comb begin
    case (st)
      S_START: want = 1'b1;
      S_BIT:   want = (bitn == 4'd8) ? (reading && left != '0) : (!reading && !shreg[7]);
      S_STOP:  want = (ph != 2'd2);
      default: want = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_q <= 1'b0;
    else if (scl_oe || st == S_START || (st == S_STOP && ph == 2'd2)) sda_q <= want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; pcnt <= '0; tcnt <= '0; bitn <= '0; stage <= '0;
      shreg <= '0; left <= '0; rd_data <= '0; rd_valid <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      if (st == S_IDLE) begin
        pcnt <= '0;
        tcnt <= '0;
        if (req && len != '0) begin
          st <= S_START; ph <= '0; stage <= '0; bitn <= '0;
          shreg <= {DEV_ADDR, 1'b0}; left <= len; err <= 1'b0;
        end
      end else begin
        if (run) begin
          pcnt <= step ? '0 : pcnt + PW'(1);
          if (step) tcnt <= end_ph ? 8'd0 : tcnt + 8'd1;
        end
        if (end_ph) begin
          case (st)
            S_START:  begin st <= S_BIT; ph <= '0; end
            S_RSTART: if (ph == 2'd0) ph <= 2'd1; else begin st <= S_START; ph <= '0; end
            S_STOP:   if (ph == 2'd2) begin st <= S_IDLE; done <= 1'b1; end else ph <= ph + 2'd1;
            S_BIT: if (ph == 2'd0) ph <= 2'd1;
              else begin
                ph <= '0;
                if (bitn != 4'd8) begin
                  bitn  <= bitn + 4'd1;
                  shreg <= {shreg[6:0], reading ? sda_i : 1'b0};
                  if (reading && bitn == 4'd7) begin
                    rd_data  <= {shreg[6:0], sda_i};
                    rd_valid <= 1'b1;
                    left     <= left - LEN_W'(1);
                  end
                end else begin
                  bitn <= '0;
                  if (!reading && sda_i) begin
                    err <= 1'b1;
                    st  <= S_STOP;
                  end else if (reading) begin
                    if (left == '0) st <= S_STOP;
                  end else begin
                    stage <= stage + 3'd1;
                    case (stage)
                      3'd0: shreg <= START_ADDR[15:8];
                      3'd1: shreg <= START_ADDR[7:0];
                      3'd2: begin shreg <= {DEV_ADDR, 1'b1}; st <= S_RSTART; end
                      default: ;
                    endcase
                  end
                end
              end
            default: ;
          endcase
        end
      end
    end
  end

  assert_sda_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && sda_oe != $past(sda_oe)) |-> (st == S_START || st == S_STOP));

  assert_err_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !rd_valid);

  assert_len0_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req && len == '0) |=> !busy);

  assert_stretch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scl_oe && !scl_i) |=> ($stable(tcnt) && $stable(pcnt)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/i2c_boot_reader_bench.sv
`timescale 1ns/1ps
module i2c_boot_reader_bench;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [15:0] len = '0;
  logic scl_oe, sda_oe, rd_valid, busy, done, err;
  logic [7:0] rd_data;
  logic scl_line, sda_line, slv_low = 1'b0, hold;
  logic stretch_en = 1'b0;
  int   hold_cnt = 0;
  int   vectors = 0, miscompares = 0;

  always #4 clk = ~clk;

  assign hold     = stretch_en && hold_cnt != 0;
  assign scl_line = !(scl_oe || hold);
  assign sda_line = !(sda_oe || slv_low);

  i2c_boot_reader u_i2c_boot_reader (
    .clk(clk), .rst_n(rst_n), .req(req), .len(len), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .done(done), .err(err));

  function automatic logic [7:0] membyte(input logic [15:0] a);
    return a[7:0] * 8'd29 + 8'h5B;
  endfunction

  always @(posedge clk) begin
    if (scl_oe) hold_cnt <= 37;
    else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1;
  end

  // EEPROM model with bus monitor
  int starts = 0, stops = 0, wcnt = 0, macks = 0, mnacks = 0, nack_at = -1;
  logic [7:0] wlog [0:255];
  int pos = 0, idx = 0, test_id = 0, seen_id = -1;
  bit rdir = 0, pend_read = 0, active = 0, ack_ok = 0, have_fall = 0, have_rise = 0;
  logic [7:0] sh = '0, cur;
  logic [15:0] ptr = '0;
  logic scl_prev = 1'b1, sda_prev = 1'b1;
  longint t_fall = 0, t_rise = 0;
  int lo_min, lo_max, hi_min, hi_max, per;

  always @(scl_line or sda_line) begin
    if (seen_id != test_id) begin
      seen_id = test_id; have_fall = 0; have_rise = 0;
      lo_min = 1000000; lo_max = 0; hi_min = 1000000; hi_max = 0;
    end
    if (scl_line === 1'b1 && scl_prev === 1'b1 && sda_line !== sda_prev) begin
      if (sda_line === 1'b0) begin
        starts++; pos = 0; idx = 0; rdir = 0; pend_read = 0; active = 1;
      end else begin
        stops++; active = 0; rdir = 0;
      end
      slv_low = 1'b0;
    end else if (scl_line !== scl_prev) begin
      if (scl_line === 1'b1) begin
        if (have_fall) begin
          per = int'(($time - t_fall) / 8);
          if (per < lo_min) lo_min = per;
          if (per > lo_max) lo_max = per;
        end
        t_rise = $time; have_rise = 1;
        if (active) begin
          if (pos < 8) begin
            sh = {sh[6:0], sda_line}; pos++;
            if (pos == 8) begin
              if (!rdir) begin
                wlog[wcnt % 256] = sh;
                ack_ok = (wcnt != nack_at) && (idx != 0 || sh[7:1] == 7'h50);
                if (idx == 0) pend_read = sh[0];
                if (idx == 1) ptr[15:8] = sh;
                if (idx == 2) ptr[7:0] = sh;
                idx++; wcnt++;
              end else ptr++;
            end
          end else begin
            pos = 0;
            if (rdir) begin
              if (sda_line === 1'b0) macks++;
              else begin mnacks++; active = 0; end
            end else if (!ack_ok) active = 0;
            else if (pend_read) rdir = 1;
          end
        end
      end else begin
        if (have_rise) begin
          per = int'(($time - t_rise) / 8);
          if (per < hi_min) hi_min = per;
          if (per > hi_max) hi_max = per;
        end
        t_fall = $time; have_fall = 1;
        if (!active) slv_low = 1'b0;
        else if (!rdir) slv_low = (pos == 8) && ack_ok;
        else if (pos < 8) begin cur = membyte(ptr); slv_low = !cur[7-pos]; end
        else slv_low = 1'b0;
      end
    end
    scl_prev = scl_line; sda_prev = sda_line;
  end

  // output capture
  int ncap = 0, ndone = 0, nbusy = 0;
  logic [7:0] cap [0:255];
  always @(negedge clk) begin
    if (rd_valid) begin cap[ncap % 256] <= rd_data; ncap <= ncap + 1; end
    if (done) ndone <= ndone + 1;
    if (busy) nbusy <= nbusy + 1;
  end

  int b_st, b_sp, b_w, b_ma, b_mn, b_cap, b_done, b_busy;

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic begin_test();
    @(negedge clk);
    test_id++;
    b_st = starts; b_sp = stops; b_w = wcnt; b_ma = macks; b_mn = mnacks;
    b_cap = ncap; b_done = ndone; b_busy = nbusy;
  endtask

  task automatic pulse_req(input int n);
    @(negedge clk); req = 1'b1; len = 16'(n);
    @(negedge clk); req = 1'b0; len = '0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (ndone == b_done && k < 60000) begin @(negedge clk); k++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_data(input string r, input int n);
    chk(r, "bytes delivered", ncap - b_cap, n);
    for (int i = 0; i < n && i < 256; i++)
      chk(r, $sformatf("byte %0d", i), cap[(b_cap + i) % 256], membyte(16'(i)));
  endtask

  task automatic t_reset();
    chk("R1", "scl_oe", scl_oe, 0);
    chk("R1", "sda_oe", sda_oe, 0);
    chk("R1", "busy/done/err/rd_valid", {busy, done, err, rd_valid}, 0);
  endtask

  task automatic t_read4();
    begin_test();
    pulse_req(4);
    wait_done();
    chk("R2", "written byte count", wcnt - b_w, 4);
    chk("R2", "device write byte", wlog[b_w % 256], 8'hA0);
    chk("R2", "address high", wlog[(b_w + 1) % 256], 8'h00);
    chk("R2", "address low", wlog[(b_w + 2) % 256], 8'h00);
    chk("R2", "device read byte", wlog[(b_w + 3) % 256], 8'hA1);
    check_data("R3", 4);
    chk("R4", "master ACKs", macks - b_ma, 3);
    chk("R4", "master NACKs", mnacks - b_mn, 1);
    chk("R7", "START edges", starts - b_st, 2);
    chk("R7", "STOP edges", stops - b_sp, 1);
    chk("R6", "SCL low min", lo_min, 170);
    chk("R6", "SCL low max", lo_max, 170);
    chk("R6", "SCL high min", hi_min, 80);
    chk("R6", "SCL high max (repeated start)", hi_max, 160);
    chk("R10", "done pulses", ndone - b_done, 1);
    chk("R10", "err after good read", err, 0);
    chk("R10", "busy after done", busy, 0);
  endtask

  task automatic t_read1();
    begin_test();
    pulse_req(1);
    wait_done();
    check_data("R3", 1);
    chk("R4", "ACKs on single byte", macks - b_ma, 0);
    chk("R4", "NACK on single byte", mnacks - b_mn, 1);
    chk("R4", "STOP after NACK", stops - b_sp, 1);
  endtask

  task automatic t_nack_dev();
    begin_test();
    nack_at = wcnt;
    pulse_req(3);
    wait_done();
    nack_at = -1;
    chk("R5", "err after device NACK", err, 1);
    chk("R5", "no data", ncap - b_cap, 0);
    chk("R5", "bytes written", wcnt - b_w, 1);
    chk("R5", "STOP issued", stops - b_sp, 1);
    chk("R5", "single START", starts - b_st, 1);
    chk("R10", "done after abort", ndone - b_done, 1);
  endtask

  task automatic t_nack_lo();
    begin_test();
    nack_at = wcnt + 2;
    pulse_req(2);
    wait_done();
    nack_at = -1;
    chk("R5", "err after address NACK", err, 1);
    chk("R5", "no data after address NACK", ncap - b_cap, 0);
    chk("R5", "bytes written before abort", wcnt - b_w, 3);
    chk("R5", "STOP after address NACK", stops - b_sp, 1);
  endtask

  task automatic t_len0();
    begin_test();
    pulse_req(0);
    repeat (600) @(negedge clk);
    chk("R9", "busy cycles after len 0", nbusy - b_busy, 0);
    chk("R9", "bus untouched after len 0", starts - b_st, 0);
    chk("R9", "err kept before next accepted request", err, 1);
  endtask

  task automatic t_stretch();
    begin_test();
    stretch_en = 1'b1;
    pulse_req(3);
    wait_done();
    stretch_en = 1'b0;
    check_data("R8", 3);
    chk("R8", "SCL high after stretch", hi_min, 80);
    chk("R8", "SCL low with stretch", lo_min, 207);
    chk("R8", "err under stretch", err, 0);
  endtask

  task automatic t_busy_req();
    begin_test();
    pulse_req(2);
    repeat (3000) @(negedge clk);
    pulse_req(7);
    wait_done();
    check_data("R9", 2);
    chk("R9", "done count with busy request", ndone - b_done, 1);
    chk("R9", "START edges with busy request", starts - b_st, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read4();
    t_read1();
    t_nack_dev();
    t_len0();
    t_nack_lo();
    t_stretch();
    t_busy_req();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule